// File: doc/BRIEF.md
# ACPI sleep command controller

This block is the power-management register file and power-state sequencer of a peripheral bus controller. Software issues a sleep request by writing a command byte that holds a "go" bit and a 3-bit sleep type. If the sleep trap is enabled, the request does not change the power state. It latches a trap status bit and holds the SMI line high, so that firmware can run before the sleep takes place. If the trap is disabled, a request with a valid type moves the power-state machine straight into the requested state.

An active-low AC-change input can wake the machine. The input is synchronized and its falling edge is detected. When the falling edge arrives while the machine sleeps and the AC-change enable is set, the machine sets a sticky wake status bit and returns to full on. A wake from suspend-to-disk or soft-off goes through a one-cycle restart indication first, because the system restarts from reset there. Status bits are cleared only by writing 1 to them. The host reaches the registers through a simple word-wide I/O bus with byte enables.

Top module: `sleep_ctrl_top`

## Requirements
- R1: After reset the power state reads 000 (full on), `smi_o` and `rst_start_o` are 0, and every register reads 0.
- R2: The command register (offset 0x00) returns the sleep type in bits [4:2] as last written. The go bit (bit 5) always reads 0, and all other bits read 0.
- R3: When the trap enable (offset 0x08, bit 0) is 1, a command write with bit 5 = 1 sets the trap status (offset 0x06, bit 0). It raises `smi_o` one cycle after the write, for any type including reserved ones, and the power state does not change.
- R4: `smi_o` stays 1 while the trap status is set. Writing 0 to the trap status bit leaves it set. Writing 1 to it clears the bit and drops `smi_o` one cycle after the write.
- R5: With the trap disabled, a command write with bit 5 = 1 and a valid type moves `pwr_state_o` to that type two cycles after the write. The valid types are 000 full on, 001 S1, 101 S3, 110 S4 and 111 S5. `pwr_state_o` never shows 010, 011 or 100.
- R6: A command write with a reserved type (010, 011, 100) or with bit 5 = 0 leaves the power state unchanged, and only updates the readable type field.
- R7: In S1 or S3 with the AC-change enable (offset 0x04, bit 12) set, a falling edge on `ac_n_i` sets the AC-change status (offset 0x02, bit 12). The state returns to 000 on the third clock edge after the input falls, and not before.
- R8: A falling edge on `ac_n_i` while in full on, or while the AC-change enable is 0, leaves the status at 0 and the state unchanged.
- R9: A wake from S4 or S5 pulses `rst_start_o` high for exactly one cycle, with `pwr_state_o` at 000. The pulse starts on the third edge after the fall and ends on the next edge. A wake from S1 or S3 gives no pulse.
- R10: The AC-change status stays set when 0 is written to it, and clears when 1 is written to bit 12.
- R11: A write changes only the bytes whose byte enable is 1 (`io_be[0]` covers bits 7:0 and `io_be[1]` covers bits 15:8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_addr | input | 8 | Register offset |
| io_be | input | 2 | Byte enables for the write |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Read data for `io_addr`, combinational |
| ac_n_i | input | 1 | Asynchronous active-low AC-change wake input |
| smi_o | output | 1 | SMI request, high while the trap status is set |
| pwr_state_o | output | 3 | Current power state as a sleep-type code |
| rst_start_o | output | 1 | One-cycle restart indication on a wake from S4/S5 |

## Verification
Register updates and `smi_o` are due one edge after the write strobe. A power-state change from a command is due on the second edge, because the request is registered before the state machine takes it. An AC wake lands on the third edge after the input falls: two synchronizer stages, then the state and status update. The restart pulse covers exactly that third-to-fourth edge window. The bench drives on falling edges and counts falling edges to the sample point. It checks the state one edge early to show that nothing moved too soon, and then again at the due edge.

// File: rtl/sleep_ctrl_pkg.sv
package sleep_ctrl_pkg;

  localparam int TYPE_W   = 3;
  localparam int TYPE_LSB = 2;
  localparam int GO_BIT   = 5;
  localparam int TRAP_BIT = 0;
  localparam int AC_BIT   = 12;

  localparam logic [TYPE_W-1:0] CODE_ON = 3'b000;
  localparam logic [TYPE_W-1:0] CODE_S1 = 3'b001;
  localparam logic [TYPE_W-1:0] CODE_S3 = 3'b101;
  localparam logic [TYPE_W-1:0] CODE_S4 = 3'b110;
  localparam logic [TYPE_W-1:0] CODE_S5 = 3'b111;

  typedef enum logic [2:0] {
    ST_ON, ST_S1, ST_S3, ST_S4, ST_S5, ST_RESTART
  } pwr_st_e;

  function automatic logic type_valid(input logic [TYPE_W-1:0] t);
    return (t == CODE_ON) || (t == CODE_S1) || (t == CODE_S3) ||
           (t == CODE_S4) || (t == CODE_S5);
  endfunction

endpackage

// File: rtl/sleep_ctrl_regs.sv
module sleep_ctrl_regs
  import sleep_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int OFS_CMD  = 'h00,
  parameter int OFS_WSTS = 'h02,
  parameter int OFS_WEN  = 'h04,
  parameter int OFS_TSTS = 'h06,
  parameter int OFS_TEN  = 'h08
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                io_wr,
  input  logic [ADDR_W-1:0]   io_addr,
  input  logic [DATA_W/8-1:0] io_be,
  input  logic [DATA_W-1:0]   io_wdata,
  output logic [DATA_W-1:0]   io_rdata,
  input  logic                ac_set_i,
  output logic                trap_en_o,
  output logic                trap_sts_o,
  output logic                ac_en_o,
  output logic                ac_sts_o,
  output logic                req_vld_o,
  output logic [TYPE_W-1:0]   req_type_o
);

  localparam int TYPE_BYTE = (TYPE_LSB + TYPE_W - 1) / 8;
  localparam int GO_BYTE   = GO_BIT / 8;
  localparam int TRAP_BYTE = TRAP_BIT / 8;
  localparam int AC_BYTE   = AC_BIT / 8;

  logic              hit_cmd, hit_wsts, hit_wen, hit_tsts, hit_ten;
  logic              go_wr;
  logic [TYPE_W-1:0] wr_type;

  logic [TYPE_W-1:0] type_q, type_d;
  logic              trap_en_q, trap_en_d;
  logic              trap_sts_q, trap_sts_d;
  logic              ac_en_q, ac_en_d;
  logic              ac_sts_q, ac_sts_d;
  logic              req_vld_q, req_vld_d;
  logic [TYPE_W-1:0] req_type_q, req_type_d;

  always_comb begin
    hit_cmd  = io_wr && (io_addr == ADDR_W'(OFS_CMD));
    hit_wsts = io_wr && (io_addr == ADDR_W'(OFS_WSTS));
    hit_wen  = io_wr && (io_addr == ADDR_W'(OFS_WEN));
    hit_tsts = io_wr && (io_addr == ADDR_W'(OFS_TSTS));
    hit_ten  = io_wr && (io_addr == ADDR_W'(OFS_TEN));
    wr_type  = io_wdata[TYPE_LSB +: TYPE_W];
    go_wr    = hit_cmd && io_be[GO_BYTE] && io_wdata[GO_BIT];
  end

  always_comb begin
    type_d     = type_q;
    trap_en_d  = trap_en_q;
    trap_sts_d = trap_sts_q;
    ac_en_d    = ac_en_q;
    ac_sts_d   = ac_sts_q;
    req_vld_d  = 1'b0;
    req_type_d = req_type_q;

    if (hit_cmd && io_be[TYPE_BYTE]) type_d = wr_type;
    if (hit_ten && io_be[TRAP_BYTE]) trap_en_d = io_wdata[TRAP_BIT];
    if (hit_wen && io_be[AC_BYTE])   ac_en_d = io_wdata[AC_BIT];

    if (hit_tsts && io_be[TRAP_BYTE] && io_wdata[TRAP_BIT]) trap_sts_d = 1'b0;
    if (go_wr && trap_en_q)                                 trap_sts_d = 1'b1;

    if (hit_wsts && io_be[AC_BYTE] && io_wdata[AC_BIT]) ac_sts_d = 1'b0;
    if (ac_set_i)                                       ac_sts_d = 1'b1;

    if (go_wr && !trap_en_q && type_valid(wr_type)) begin
      req_vld_d  = 1'b1;
      req_type_d = wr_type;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q     <= '0;
      trap_en_q  <= 1'b0;
      trap_sts_q <= 1'b0;
      ac_en_q    <= 1'b0;
      ac_sts_q   <= 1'b0;
      req_vld_q  <= 1'b0;
      req_type_q <= '0;
    end else begin
      type_q     <= type_d;
      trap_en_q  <= trap_en_d;
      trap_sts_q <= trap_sts_d;
      ac_en_q    <= ac_en_d;
      ac_sts_q   <= ac_sts_d;
      req_vld_q  <= req_vld_d;
      req_type_q <= req_type_d;
    end
  end

  always_comb begin
    io_rdata = '0;
    if (io_addr == ADDR_W'(OFS_CMD))  io_rdata[TYPE_LSB +: TYPE_W] = type_q;
    if (io_addr == ADDR_W'(OFS_WSTS)) io_rdata[AC_BIT]   = ac_sts_q;
    if (io_addr == ADDR_W'(OFS_WEN))  io_rdata[AC_BIT]   = ac_en_q;
    if (io_addr == ADDR_W'(OFS_TSTS)) io_rdata[TRAP_BIT] = trap_sts_q;
    if (io_addr == ADDR_W'(OFS_TEN))  io_rdata[TRAP_BIT] = trap_en_q;
  end

  logic unused_wdata;
  assign unused_wdata = ^io_wdata;

  assign trap_en_o  = trap_en_q;
  assign trap_sts_o = trap_sts_q;
  assign ac_en_o    = ac_en_q;
  assign ac_sts_o   = ac_sts_q;
  assign req_vld_o  = req_vld_q;
  assign req_type_o = req_type_q;

endmodule

// File: rtl/sleep_ctrl_fall_det.sv
module sleep_ctrl_fall_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n_i,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b1;
        else        sync_q[i] <= async_n_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b1;
        else        sync_q[i] <= sync_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign fall_o = prev_q && !sync_q[STAGES-1];

endmodule

// File: rtl/sleep_ctrl_fsm.sv
module sleep_ctrl_fsm
  import sleep_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld_i,
  input  logic [TYPE_W-1:0] req_type_i,
  input  logic              fall_i,
  input  logic              ac_en_i,
  output logic              wake_take_o,
  output logic [TYPE_W-1:0] pwr_code_o,
  output logic              rst_start_o
);

  pwr_st_e state_q, state_d;
  logic    sleeping;

  always_comb begin
    sleeping    = (state_q == ST_S1) || (state_q == ST_S3) ||
                  (state_q == ST_S4) || (state_q == ST_S5);
    wake_take_o = fall_i && ac_en_i && sleeping;
  end

  always_comb begin
    state_d = state_q;
    if (wake_take_o) begin
      if ((state_q == ST_S4) || (state_q == ST_S5)) state_d = ST_RESTART;
      else                                          state_d = ST_ON;
    end else if (state_q == ST_RESTART) begin
      state_d = ST_ON;
    end else if (req_vld_i) begin
      case (req_type_i)
        CODE_S1: state_d = ST_S1;
        CODE_S3: state_d = ST_S3;
        CODE_S4: state_d = ST_S4;
        CODE_S5: state_d = ST_S5;
        default: state_d = ST_ON;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_ON;
    else        state_q <= state_d;
  end

  always_comb begin
    case (state_q)
      ST_S1:   pwr_code_o = CODE_S1;
      ST_S3:   pwr_code_o = CODE_S3;
      ST_S4:   pwr_code_o = CODE_S4;
      ST_S5:   pwr_code_o = CODE_S5;
      default: pwr_code_o = CODE_ON;
    endcase
    rst_start_o = (state_q == ST_RESTART);
  end

endmodule

// File: rtl/sleep_ctrl_top.sv
module sleep_ctrl_top
  import sleep_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int OFS_CMD     = 'h00,
  parameter int OFS_WSTS    = 'h02,
  parameter int OFS_WEN     = 'h04,
  parameter int OFS_TSTS    = 'h06,
  parameter int OFS_TEN     = 'h08
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                io_wr,
  input  logic [ADDR_W-1:0]   io_addr,
  input  logic [DATA_W/8-1:0] io_be,
  input  logic [DATA_W-1:0]   io_wdata,
  output logic [DATA_W-1:0]   io_rdata,
  input  logic                ac_n_i,
  output logic                smi_o,
  output logic [TYPE_W-1:0]   pwr_state_o,
  output logic                rst_start_o
);

  logic              wake_take_w;
  logic              trap_en_w, trap_sts_w, ac_en_w, ac_sts_w;
  logic              req_vld_w;
  logic [TYPE_W-1:0] req_type_w;
  logic              fall_w;

  sleep_ctrl_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .OFS_CMD(OFS_CMD), .OFS_WSTS(OFS_WSTS), .OFS_WEN(OFS_WEN),
    .OFS_TSTS(OFS_TSTS), .OFS_TEN(OFS_TEN)
  ) regs_i (
    .clk(clk), .rst_n(rst_n),
    .io_wr(io_wr), .io_addr(io_addr), .io_be(io_be),
    .io_wdata(io_wdata), .io_rdata(io_rdata),
    .ac_set_i(wake_take_w),
    .trap_en_o(trap_en_w), .trap_sts_o(trap_sts_w),
    .ac_en_o(ac_en_w), .ac_sts_o(ac_sts_w),
    .req_vld_o(req_vld_w), .req_type_o(req_type_w)
  );

  sleep_ctrl_fall_det #(.STAGES(SYNC_STAGES)) fall_i (
    .clk(clk), .rst_n(rst_n), .async_n_i(ac_n_i), .fall_o(fall_w)
  );

  sleep_ctrl_fsm fsm_i (
    .clk(clk), .rst_n(rst_n),
    .req_vld_i(req_vld_w), .req_type_i(req_type_w),
    .fall_i(fall_w), .ac_en_i(ac_en_w),
    .wake_take_o(wake_take_w),
    .pwr_code_o(pwr_state_o), .rst_start_o(rst_start_o)
  );

  assign smi_o = trap_sts_w;

endmodule

// File: rtl/sleep_ctrl_chk.sv
module sleep_ctrl_chk #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int OFS_CMD  = 'h00,
  parameter int OFS_WSTS = 'h02,
  parameter int OFS_TSTS = 'h06
) (
  input logic                clk,
  input logic                rst_n,
  input logic                io_wr,
  input logic [ADDR_W-1:0]   io_addr,
  input logic [DATA_W/8-1:0] io_be,
  input logic [DATA_W-1:0]   io_wdata,
  input logic                smi,
  input logic [2:0]          pwr_state,
  input logic                rst_start,
  input logic                trap_en,
  input logic                ac_sts
);

  logic trap_cmd, trap_clr, ac_clr;
  assign trap_cmd = io_wr && (io_addr == ADDR_W'(OFS_CMD)) && io_be[0] && io_wdata[5] && trap_en;
  assign trap_clr = io_wr && (io_addr == ADDR_W'(OFS_TSTS)) && io_be[0] && io_wdata[0];
  assign ac_clr   = io_wr && (io_addr == ADDR_W'(OFS_WSTS)) && io_be[1] && io_wdata[12];

  AST_TRAP_RAISES_SMI: assert property (@(posedge clk) disable iff (!rst_n)
    trap_cmd |=> smi); // R3

  AST_TRAP_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_cmd && pwr_state == 3'b000 && !rst_start) |=> ##1 $stable(pwr_state)); // R3

  AST_SMI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (smi && !trap_clr) |=> smi); // R4

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwr_state inside {3'b010, 3'b011, 3'b100})); // R5

  AST_WAKE_TO_ON: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ac_sts) |-> (pwr_state == 3'b000)); // R7

  AST_RESTART_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_start |=> !rst_start); // R9

  AST_RESTART_REPORTS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    rst_start |-> (pwr_state == 3'b000)); // R9

  AST_ACSTS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ac_sts && !ac_clr) |=> ac_sts); // R10

endmodule

bind sleep_ctrl_top sleep_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .OFS_CMD(OFS_CMD), .OFS_WSTS(OFS_WSTS), .OFS_TSTS(OFS_TSTS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
  .io_be(io_be), .io_wdata(io_wdata), .smi(smi_o),
  .pwr_state(pwr_state_o), .rst_start(rst_start_o),
  .trap_en(trap_en_w), .ac_sts(ac_sts_w)
);

// File: tb/sleep_ctrl_top_tb_top.sv
module sleep_ctrl_top_tb_top;

  logic        clk;
  logic        rst_n;
  logic        io_wr;
  logic [7:0]  io_addr;
  logic [1:0]  io_be;
  logic [15:0] io_wdata;
  logic [15:0] io_rdata;
  logic        ac_n_i;
  logic        smi_o;
  logic [2:0]  pwr_state_o;
  logic        rst_start_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  sleep_ctrl_top dut_i (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_be(io_be), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .ac_n_i(ac_n_i), .smi_o(smi_o), .pwr_state_o(pwr_state_o),
    .rst_start_o(rst_start_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  localparam logic [7:0] A_CMD = 8'h00, A_WSTS = 8'h02, A_WEN = 8'h04,
                         A_TSTS = 8'h06, A_TEN = 8'h08;

  typedef struct packed {
    logic [7:0]  addr;
    logic [1:0]  be;
    logic [15:0] wdata;
    logic [2:0]  exp_state;
    logic        exp_smi;
    logic [7:0]  rd_addr;
    logic [15:0] exp_rd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 2'b01, 16'h0024, 3'b001, 1'b0, 8'h00, 16'h0004, 4'd5},  // R5 S1, R2 readback
    '{8'h00, 2'b01, 16'h0020, 3'b000, 1'b0, 8'h00, 16'h0000, 4'd5},
    '{8'h00, 2'b01, 16'h0034, 3'b101, 1'b0, 8'h00, 16'h0014, 4'd5},  // S3
    '{8'h00, 2'b01, 16'h0020, 3'b000, 1'b0, 8'h00, 16'h0000, 4'd5},
    '{8'h00, 2'b01, 16'h0038, 3'b110, 1'b0, 8'h00, 16'h0018, 4'd5},  // S4
    '{8'h00, 2'b01, 16'h0020, 3'b000, 1'b0, 8'h00, 16'h0000, 4'd5},
    '{8'h00, 2'b01, 16'h003C, 3'b111, 1'b0, 8'h00, 16'h001C, 4'd5},  // S5
    '{8'h00, 2'b01, 16'h0020, 3'b000, 1'b0, 8'h00, 16'h0000, 4'd5},
    '{8'h00, 2'b01, 16'h0028, 3'b000, 1'b0, 8'h00, 16'h0008, 4'd6},  // R6 reserved 010
    '{8'h00, 2'b01, 16'h002C, 3'b000, 1'b0, 8'h00, 16'h000C, 4'd6},  // R6 reserved 011
    '{8'h00, 2'b01, 16'h0030, 3'b000, 1'b0, 8'h00, 16'h0010, 4'd6},  // R6 reserved 100
    '{8'h00, 2'b01, 16'h0014, 3'b000, 1'b0, 8'h00, 16'h0014, 4'd6},  // R6 go bit 0
    '{8'h00, 2'b10, 16'h0024, 3'b000, 1'b0, 8'h00, 16'h0014, 4'd11}, // R11 low byte masked
    '{8'h08, 2'b01, 16'h0001, 3'b000, 1'b0, 8'h08, 16'h0001, 4'd3},  // trap enable on
    '{8'h00, 2'b01, 16'h0024, 3'b000, 1'b1, 8'h06, 16'h0001, 4'd3},  // R3 trapped
    '{8'h06, 2'b01, 16'h0000, 3'b000, 1'b1, 8'h06, 16'h0001, 4'd4},  // R4 write 0
    '{8'h06, 2'b01, 16'h0001, 3'b000, 1'b0, 8'h06, 16'h0000, 4'd4},  // R4 write 1
    '{8'h00, 2'b01, 16'h002C, 3'b000, 1'b1, 8'h06, 16'h0001, 4'd3},  // R3 reserved trapped
    '{8'h06, 2'b01, 16'h0001, 3'b000, 1'b0, 8'h06, 16'h0000, 4'd4},
    '{8'h08, 2'b01, 16'h0000, 3'b000, 1'b0, 8'h08, 16'h0000, 4'd3},
    '{8'h04, 2'b01, 16'h1000, 3'b000, 1'b0, 8'h04, 16'h0000, 4'd11}, // R11 high byte masked
    '{8'h04, 2'b11, 16'h1000, 3'b000, 1'b0, 8'h04, 16'h1000, 4'd11}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_be = be; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0; io_be = 2'b00; io_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
    io_addr = a;
    #1;
    d = io_rdata;
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drop_ac();
    @(negedge clk);
    ac_n_i = 1'b0;
  endtask

  task automatic lift_ac();
    @(negedge clk);
    ac_n_i = 1'b1;
    wait_neg(4);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] rd;
    rst_n = 1'b0; io_wr = 1'b0; io_addr = '0; io_be = '0; io_wdata = '0; ac_n_i = 1'b1;
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(1);

    // R1 reset state
    check("R1 state", 16'(pwr_state_o), 16'h0000);
    check("R1 smi", 16'(smi_o), 16'h0000);
    check("R1 rst_start", 16'(rst_start_o), 16'h0000);
    bus_read(A_CMD, rd);  check("R1 cmd", rd, 16'h0000);
    bus_read(A_WSTS, rd); check("R1 wsts", rd, 16'h0000);
    bus_read(A_WEN, rd);  check("R1 wen", rd, 16'h0000);
    bus_read(A_TSTS, rd); check("R1 tsts", rd, 16'h0000);
    bus_read(A_TEN, rd);  check("R1 ten", rd, 16'h0000);

    // Vector walk: write, then three falling edges before sampling
    for (int i = 0; i < NV; i++) begin
      bus_write(VECS[i].addr, VECS[i].be, VECS[i].wdata);
      wait_neg(2);
      check($sformatf("R%0d vec%0d state", VECS[i].req, i), 16'(pwr_state_o), 16'(VECS[i].exp_state));
      check($sformatf("R%0d vec%0d smi", VECS[i].req, i), 16'(smi_o), 16'(VECS[i].exp_smi));
      bus_read(VECS[i].rd_addr, rd);
      check($sformatf("R%0d vec%0d read", VECS[i].req, i), rd, VECS[i].exp_rd);
    end

    // R3 / R5 timing: SMI one edge after the write; state two edges after
    bus_write(A_CMD, 2'b01, 16'h0024);
    check("R5 state not yet", 16'(pwr_state_o), 16'h0000);
    wait_neg(1);
    check("R5 state at second edge", 16'(pwr_state_o), 16'h0001);
    bus_write(A_CMD, 2'b01, 16'h0020);
    wait_neg(2);

    // R8: AC fall in full on is ignored (enable is 1 here)
    drop_ac(); wait_neg(4);
    check("R8 on state", 16'(pwr_state_o), 16'h0000);
    bus_read(A_WSTS, rd); check("R8 on sts", rd, 16'h0000);
    lift_ac();

    // R7: wake from S1, due on the third edge after the fall
    bus_write(A_CMD, 2'b01, 16'h0024); wait_neg(2);
    drop_ac(); wait_neg(2);
    check("R7 S1 before due edge", 16'(pwr_state_o), 16'h0001);
    wait_neg(1);
    check("R7 S1 woke", 16'(pwr_state_o), 16'h0000);
    check("R9 no pulse from S1", 16'(rst_start_o), 16'h0000);
    bus_read(A_WSTS, rd); check("R7 sts set", rd, 16'h1000);
    lift_ac();

    // R10: write 0 keeps, write 1 clears
    bus_write(A_WSTS, 2'b11, 16'h0000);
    bus_read(A_WSTS, rd); check("R10 write0 keeps", rd, 16'h1000);
    bus_write(A_WSTS, 2'b11, 16'h1000);
    bus_read(A_WSTS, rd); check("R10 write1 clears", rd, 16'h0000);

    // R7: wake from S3
    bus_write(A_CMD, 2'b01, 16'h0034); wait_neg(2);
    check("R7 in S3", 16'(pwr_state_o), 16'h0005);
    drop_ac(); wait_neg(3);
    check("R7 S3 woke", 16'(pwr_state_o), 16'h0000);
    lift_ac();
    bus_write(A_WSTS, 2'b10, 16'h1000);

    // R9: wake from S4 gives a one-cycle restart pulse
    bus_write(A_CMD, 2'b01, 16'h0038); wait_neg(2);
    drop_ac(); wait_neg(2);
    check("R9 S4 pulse not yet", 16'(rst_start_o), 16'h0000);
    wait_neg(1);
    check("R9 S4 pulse", 16'(rst_start_o), 16'h0001);
    check("R9 S4 state on", 16'(pwr_state_o), 16'h0000);
    wait_neg(1);
    check("R9 S4 pulse ended", 16'(rst_start_o), 16'h0000);
    check("R9 S4 after", 16'(pwr_state_o), 16'h0000);
    lift_ac();
    bus_write(A_WSTS, 2'b10, 16'h1000);

    // R9: wake from S5
    bus_write(A_CMD, 2'b01, 16'h003C); wait_neg(2);
    drop_ac(); wait_neg(3);
    check("R9 S5 pulse", 16'(rst_start_o), 16'h0001);
    wait_neg(1);
    check("R9 S5 pulse ended", 16'(rst_start_o), 16'h0000);
    lift_ac();
    bus_write(A_WSTS, 2'b10, 16'h1000);

    // R8: enable clear, fall in S3 is ignored
    bus_write(A_WEN, 2'b11, 16'h0000);
    bus_write(A_CMD, 2'b01, 16'h0034); wait_neg(2);
    drop_ac(); wait_neg(4);
    check("R8 disabled state", 16'(pwr_state_o), 16'h0005);
    bus_read(A_WSTS, rd); check("R8 disabled sts", rd, 16'h0000);
    lift_ac();
    bus_write(A_CMD, 2'b01, 16'h0020); wait_neg(2);
    check("R5 back to on", 16'(pwr_state_o), 16'h0000);

    // R2: go bit never reads back
    bus_read(A_CMD, rd); check("R2 go bit reads 0", rd, 16'h0000);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule